// File: doc/BRIEF.md
# Parallel Port Unlock Sequence Detector

This block sits on the peripheral side of a PC parallel port. It watches the eight data lines and the four control lines. It wakes the adapter only after a fixed seven-byte key has been written to the data lines, followed by a command byte and a strobe on the control lines. A connect command attaches the adapter and a disconnect command detaches it. Any other command value is recorded but changes nothing.

While the key is being written, the block places a 12-bit identification code on the upper status nibble, one nibble per step. A host can therefore probe for the adapter without connecting to it. Every port input passes through a synchroniser. A new data value, or a new control value, is recognised when the synchronised lines change. A byte that breaks the key restarts the matcher. If that byte is itself the first key byte, it begins a fresh attempt.

Top module: `pp_unlock_detect`

## Requirements
- R1: After reset, `connected` is 0, `status_nib` is 0x0 and `last_cmd` is 0x00.
- R2: The key is the data values 0xFE, 0xAA, 0x55, 0x00, 0xFF, 0x87, 0x78 in that order. After the key, the next data value is the command. The command takes effect when the control lines then go from 4 to 5 and back to 4. Command 0x20 sets `connected` to 1 and `last_cmd` to 0x20.
- R3: A strobed command 0x30 clears `connected` and sets `last_cmd` to 0x30.
- R4: `status_nib` shows 0xB while the 0xFF key byte is the last one matched. It shows 0x5 while 0x87 is the last one matched. It shows 0xF while the control lines are at 5 during the command strobe. In every other state it shows 0x0.
- R5: A data value that does not match the next expected key byte sends the matcher back to the start. Key bytes that come after the break do not complete a key.
- R6: A break value of 0xFE counts as the first byte of a new key. The key then completes without any further 0xFE.
- R7: A captured command is dropped if, before the strobe completes, a new data value arrives or the control lines take any value other than 4 or 5.
- R8: A strobed command other than 0x20 or 0x30 leaves `connected` unchanged and still updates `last_cmd`.
- R9: Disconnecting twice leaves the block disconnected. A later connect still works.
- R10: A port change reaches the outputs after the third rising clock edge and not before. Two of those edges are synchroniser stages and one is the matcher register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pdata | input | 8 | Parallel data lines from the host |
| pctrl | input | 4 | Parallel control lines from the host |
| status_nib | output | 4 | Upper status nibble returned to the host |
| connected | output | 1 | Adapter attached |
| last_cmd | output | 8 | Most recently strobed command byte |

## Verification
The bench works through the following cases:

- **Key broken by 0xFE.** The bench restarts a key midway with 0xFE. A matcher that falls to idle on any mismatch would miss the connect.
- **Key broken by a foreign byte.** The bench inserts a foreign byte and then finishes the remaining key bytes. A matcher that skips bad bytes would connect wrongly.
- **Aborted strobe.** The strobe is aborted once by a stray control value and once by a new data value. A design that latches the command on capture, rather than on the strobe, would change `connected`.
- **Undefined command and repeated disconnect.** These show whether undefined commands disturb the connection state.
- **Nibble timing.** The three identification nibbles are sampled at each step. A mistimed or misordered nibble would break host probing.
- **Latency.** The strobe latency is measured edge by edge.

// File: rtl/pp_unlock_pkg.sv
package pp_unlock_pkg;

   localparam int KEY_LEN  = 7;
   localparam int IDX_W    = $clog2(KEY_LEN + 1);
   localparam int STEP_HI  = KEY_LEN - 2;
   localparam int STEP_MID = KEY_LEN - 1;

   typedef enum logic [1:0] {
      PH_MATCH = 2'd0,
      PH_ARM   = 2'd1,
      PH_HIGH  = 2'd2
   } phase_t;

   function automatic logic [7:0] key_byte(input logic [IDX_W-1:0] i);
      logic [7:0] v;
      case (i)
         3'd0:    v = 8'hFE;
         3'd1:    v = 8'hAA;
         3'd2:    v = 8'h55;
         3'd3:    v = 8'h00;
         3'd4:    v = 8'hFF;
         3'd5:    v = 8'h87;
         3'd6:    v = 8'h78;
         default: v = 8'h00;
      endcase
      return v;
   endfunction

endpackage

// File: rtl/pp_sync_bus.sv
module pp_sync_bus #(
   parameter int          WIDTH  = 8,
   parameter int          STAGES = 2,
   parameter logic [WIDTH-1:0] RST_VAL = '0
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] d_in,
   output logic [WIDTH-1:0] d_out
);

   if (STAGES < 2) begin : g_bad_stages
      $error("pp_sync_bus: STAGES must be at least 2");
   end
   if (WIDTH < 1) begin : g_bad_width
      $error("pp_sync_bus: WIDTH must be positive");
   end

   logic [WIDTH-1:0] chain [STAGES];

   for (genvar s = 0; s < STAGES; s++) begin : g_stage
      if (s == 0) begin : g_first
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) chain[s] <= RST_VAL;
            else        chain[s] <= d_in;
         end
      end else begin : g_next
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) chain[s] <= RST_VAL;
            else        chain[s] <= chain[s-1];
         end
      end
   end

   assign d_out = chain[STAGES-1];

endmodule

// File: rtl/pp_change_det.sv
module pp_change_det #(
   parameter int               WIDTH   = 8,
   parameter logic [WIDTH-1:0] RST_VAL = '0
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] cur,
   output logic             changed
);

   logic [WIDTH-1:0] prev_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) prev_q <= RST_VAL;
      else        prev_q <= cur;
   end

   assign changed = (cur != prev_q);

endmodule

// File: rtl/pp_unlock_fsm.sv
module pp_unlock_fsm
   import pp_unlock_pkg::*;
#(
   parameter int         CTRL_W   = 4,
   parameter logic [7:0] CMD_ATT  = 8'h20,
   parameter logic [7:0] CMD_DET  = 8'h30,
   parameter logic [CTRL_W-1:0] STB_LO = 4'd4,
   parameter logic [CTRL_W-1:0] STB_HI = 4'd5
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              byte_ev,
   input  logic [7:0]        byte_val,
   input  logic              ctrl_ev,
   input  logic [CTRL_W-1:0] ctrl_val,
   output phase_t            phase,
   output logic [IDX_W-1:0]  idx,
   output logic              attached,
   output logic [7:0]        cmd
);

   if (CMD_ATT == CMD_DET) begin : g_bad_cmd
      $error("pp_unlock_fsm: connect and disconnect codes must differ");
   end
   if (STB_LO == STB_HI) begin : g_bad_stb
      $error("pp_unlock_fsm: strobe levels must differ");
   end

   phase_t           phase_q, phase_n;
   logic [IDX_W-1:0] idx_q, idx_n;
   logic [7:0]       cand_q, cand_n;
   logic [7:0]       cmd_q, cmd_n;
   logic             att_q, att_n;
   logic             key_done;
   logic             key_hit;
   logic             is_first;

   assign key_done = (phase_q == PH_MATCH) && (idx_q == IDX_W'(KEY_LEN));
   assign key_hit  = (phase_q == PH_MATCH) && (idx_q <  IDX_W'(KEY_LEN))
                     && (byte_val == key_byte(idx_q));
   assign is_first = (byte_val == key_byte('0));

   always_comb begin
      phase_n = phase_q;
      idx_n   = idx_q;
      cand_n  = cand_q;
      cmd_n   = cmd_q;
      att_n   = att_q;
      if (byte_ev) begin
         if (key_done) begin
            cand_n  = byte_val;
            phase_n = PH_ARM;
            idx_n   = '0;
         end else if (key_hit) begin
            idx_n = idx_q + 1'b1;
         end else begin
            phase_n = PH_MATCH;
            idx_n   = is_first ? IDX_W'(1) : '0;
         end
      end else if (ctrl_ev) begin
         case (phase_q)
            PH_ARM: begin
               if (ctrl_val == STB_HI) begin
                  phase_n = PH_HIGH;
               end else if (ctrl_val != STB_LO) begin
                  phase_n = PH_MATCH;
                  idx_n   = '0;
               end
            end
            PH_HIGH: begin
               phase_n = PH_MATCH;
               idx_n   = '0;
               if (ctrl_val == STB_LO) begin
                  cmd_n = cand_q;
                  if (cand_q == CMD_ATT)      att_n = 1'b1;
                  else if (cand_q == CMD_DET) att_n = 1'b0;
               end
            end
            default: ;
         endcase
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         phase_q <= PH_MATCH;
         idx_q   <= '0;
         cand_q  <= '0;
         cmd_q   <= '0;
         att_q   <= 1'b0;
      end else begin
         phase_q <= phase_n;
         idx_q   <= idx_n;
         cand_q  <= cand_n;
         cmd_q   <= cmd_n;
         att_q   <= att_n;
      end
   end

   assign phase    = phase_q;
   assign idx      = idx_q;
   assign attached = att_q;
   assign cmd      = cmd_q;

endmodule

// File: rtl/pp_status_mux.sv
module pp_status_mux
   import pp_unlock_pkg::*;
#(
   parameter int          ID_W    = 12,
   parameter logic [ID_W-1:0] ID_CODE = 12'hB5F,
   parameter logic [3:0]  NEUTRAL = 4'h0
) (
   input  phase_t           phase,
   input  logic [IDX_W-1:0] idx,
   output logic [3:0]       nib
);

   localparam int NIBS = ID_W / 4;

   if (ID_W != 12) begin : g_bad_id
      $error("pp_status_mux: identification code must be three nibbles");
   end

   logic [3:0] part [NIBS];

   for (genvar k = 0; k < NIBS; k++) begin : g_part
      assign part[k] = ID_CODE[ID_W-1-4*k -: 4];
   end

   always_comb begin
      nib = NEUTRAL;
      if (phase == PH_HIGH)
         nib = part[2];
      else if (phase == PH_MATCH && idx == IDX_W'(STEP_HI))
         nib = part[0];
      else if (phase == PH_MATCH && idx == IDX_W'(STEP_MID))
         nib = part[1];
   end

endmodule

// File: rtl/pp_unlock_detect.sv
module pp_unlock_detect
   import pp_unlock_pkg::*;
#(
   parameter int         DATA_W      = 8,
   parameter int         CTRL_W      = 4,
   parameter int         SYNC_STAGES = 2,
   parameter int         ID_W        = 12,
   parameter logic [ID_W-1:0] ID_CODE = 12'hB5F,
   parameter logic [7:0] CMD_ATT     = 8'h20,
   parameter logic [7:0] CMD_DET     = 8'h30
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [DATA_W-1:0] pdata,
   input  logic [CTRL_W-1:0] pctrl,
   output logic [3:0]        status_nib,
   output logic              connected,
   output logic [7:0]        last_cmd
);

   if (DATA_W != 8) begin : g_bad_data
      $error("pp_unlock_detect: data path must be one byte");
   end
   if (CTRL_W != 4) begin : g_bad_ctrl
      $error("pp_unlock_detect: control path must be one nibble");
   end

   logic [DATA_W-1:0] data_s;
   logic [CTRL_W-1:0] ctrl_s;
   logic              data_chg;
   logic              ctrl_chg;
   phase_t            phase;
   logic [IDX_W-1:0]  idx;

   pp_sync_bus #(.WIDTH(DATA_W), .STAGES(SYNC_STAGES), .RST_VAL('0)) u_sync_data (
      .clk(clk), .rst_n(rst_n), .d_in(pdata), .d_out(data_s)
   );

   pp_sync_bus #(.WIDTH(CTRL_W), .STAGES(SYNC_STAGES), .RST_VAL('0)) u_sync_ctrl (
      .clk(clk), .rst_n(rst_n), .d_in(pctrl), .d_out(ctrl_s)
   );

   pp_change_det #(.WIDTH(DATA_W), .RST_VAL('0)) u_chg_data (
      .clk(clk), .rst_n(rst_n), .cur(data_s), .changed(data_chg)
   );

   pp_change_det #(.WIDTH(CTRL_W), .RST_VAL('0)) u_chg_ctrl (
      .clk(clk), .rst_n(rst_n), .cur(ctrl_s), .changed(ctrl_chg)
   );

   pp_unlock_fsm #(
      .CTRL_W(CTRL_W), .CMD_ATT(CMD_ATT), .CMD_DET(CMD_DET),
      .STB_LO(4'd4), .STB_HI(4'd5)
   ) u_fsm (
      .clk(clk), .rst_n(rst_n),
      .byte_ev(data_chg), .byte_val(data_s),
      .ctrl_ev(ctrl_chg), .ctrl_val(ctrl_s),
      .phase(phase), .idx(idx),
      .attached(connected), .cmd(last_cmd)
   );

   pp_status_mux #(.ID_W(ID_W), .ID_CODE(ID_CODE), .NEUTRAL(4'h0)) u_status (
      .phase(phase), .idx(idx), .nib(status_nib)
   );

endmodule

// File: rtl/pp_unlock_checker.sv
module pp_unlock_checker (
   input logic       clk,
   input logic       rst_n,
   input logic [3:0] pctrl,
   input logic [3:0] status_nib,
   input logic       connected,
   input logic [7:0] last_cmd
);

   p_reset_clear_r1: assert property (@(posedge clk)
      !rst_n |=> (!connected && status_nib == 4'h0 && last_cmd == 8'h00));

   p_attach_code_r2: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(connected) |-> last_cmd == 8'h20);

   p_detach_code_r3: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(connected) |-> last_cmd == 8'h30);

   p_nib_legal_r4: assert property (@(posedge clk) disable iff (!rst_n)
      status_nib == 4'h0 || status_nib == 4'hB ||
      status_nib == 4'h5 || status_nib == 4'hF);

   p_mid_after_hi_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (status_nib == 4'h5 && !$stable(status_nib)) |-> $past(status_nib) == 4'hB);

   p_other_cmd_keeps_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (!$stable(last_cmd) && last_cmd != 8'h20 && last_cmd != 8'h30)
      |-> $stable(connected));

   p_cmd_on_strobe_r2: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(last_cmd) |-> pctrl == 4'd4 || $past(pctrl) == 4'd4);

endmodule

bind pp_unlock_detect pp_unlock_checker u_chk (
   .clk(clk), .rst_n(rst_n), .pctrl(pctrl), .status_nib(status_nib),
   .connected(connected), .last_cmd(last_cmd)
);

// File: tb/tb_pp_unlock_detect.sv
module tb_pp_unlock_detect;

   localparam time CLK_PERIOD = 10ns;
   localparam int  HOLD       = 4;
   localparam int  WATCHDOG   = 20000;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic [7:0] pdata = 8'hFF;
   logic [3:0] pctrl = 4'd4;
   logic [3:0] status_nib;
   logic       connected;
   logic [7:0] last_cmd;

   int n_checks = 0;
   int n_bad    = 0;
   bit finished = 1'b0;

   always #(CLK_PERIOD/2) clk = ~clk;

   pp_unlock_detect dut (
      .clk(clk), .rst_n(rst_n), .pdata(pdata), .pctrl(pctrl),
      .status_nib(status_nib), .connected(connected), .last_cmd(last_cmd)
   );

   task automatic check(input string req, input int act, input int exp);
      n_checks++;
      if (act != exp) begin
         n_bad++;
         $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
      end
   endtask

   task automatic put_data(input logic [7:0] b);
      @(negedge clk) pdata = b;
      repeat (HOLD) @(negedge clk);
   endtask

   task automatic put_ctrl(input logic [3:0] c);
      @(negedge clk) pctrl = c;
      repeat (HOLD) @(negedge clk);
   endtask

   task automatic send_key();
      put_data(8'hFE); put_data(8'hAA); put_data(8'h55); put_data(8'h00);
      put_data(8'hFF); put_data(8'h87); put_data(8'h78);
   endtask

   task automatic full_cmd(input logic [7:0] c);
      send_key();
      put_data(c);
      put_ctrl(4'd5);
      put_ctrl(4'd4);
      put_data(8'hFF);
   endtask

   task automatic t_reset();
      check("R1 connected", connected, 0);
      check("R1 status", status_nib, 0);
      check("R1 last_cmd", last_cmd, 0);
   endtask

   task automatic t_probe_connect();
      put_data(8'hFE); put_data(8'hAA); put_data(8'h55); put_data(8'h00);
      put_data(8'hFF);
      check("R4 nibble after 0xFF", status_nib, 4'hB);
      put_data(8'h87);
      check("R4 nibble after 0x87", status_nib, 4'h5);
      put_data(8'h78);
      check("R4 nibble after 0x78", status_nib, 4'h0);
      put_data(8'h20);
      check("R4 nibble while armed", status_nib, 4'h0);
      put_ctrl(4'd5);
      check("R4 nibble strobe high", status_nib, 4'hF);
      check("R2 not yet connected", connected, 0);
      @(negedge clk) pctrl = 4'd4;
      repeat (2) @(negedge clk);
      check("R10 no change after two edges", connected, 0);
      @(negedge clk);
      check("R10 change after third edge", connected, 1);
      check("R2 connected", connected, 1);
      check("R2 last_cmd", last_cmd, 8'h20);
      check("R4 nibble after strobe", status_nib, 4'h0);
      put_data(8'hFF);
   endtask

   task automatic t_disconnect();
      full_cmd(8'h30);
      check("R3 disconnected", connected, 0);
      check("R3 last_cmd", last_cmd, 8'h30);
   endtask

   task automatic t_break();
      put_data(8'hFE); put_data(8'hAA); put_data(8'h13);
      put_data(8'h55); put_data(8'h00); put_data(8'hFF);
      check("R5 no id after broken key", status_nib, 4'h0);
      put_data(8'h87); put_data(8'h78); put_data(8'h20);
      put_ctrl(4'd5); put_ctrl(4'd4);
      check("R5 broken key ignored", connected, 0);
      check("R5 last_cmd unchanged", last_cmd, 8'h30);
      put_data(8'hFF);
   endtask

   task automatic t_fe_restart();
      put_data(8'hFE); put_data(8'hAA); put_data(8'h55);
      put_data(8'hFE); put_data(8'hAA); put_data(8'h55); put_data(8'h00);
      put_data(8'hFF);
      check("R6 id after restart", status_nib, 4'hB);
      put_data(8'h87); put_data(8'h78); put_data(8'h20);
      put_ctrl(4'd5); put_ctrl(4'd4);
      check("R6 connected after 0xFE restart", connected, 1);
      put_data(8'hFF);
   endtask

   task automatic t_abort();
      send_key();
      put_data(8'h30);
      put_ctrl(4'd5);
      put_ctrl(4'd6);
      put_ctrl(4'd4);
      check("R7 stray control aborts", connected, 1);
      check("R7 last_cmd kept", last_cmd, 8'h20);
      put_data(8'hFF);
      send_key();
      put_data(8'h30);
      put_data(8'h11);
      put_ctrl(4'd5);
      put_ctrl(4'd4);
      check("R7 new data aborts", connected, 1);
      check("R7 last_cmd kept after data", last_cmd, 8'h20);
      put_data(8'hFF);
   endtask

   task automatic t_unknown();
      full_cmd(8'h55);
      check("R8 connection kept", connected, 1);
      check("R8 last_cmd recorded", last_cmd, 8'h55);
   endtask

   task automatic t_repeat_disc();
      full_cmd(8'h30);
      check("R9 first disconnect", connected, 0);
      full_cmd(8'h30);
      check("R9 second disconnect", connected, 0);
      full_cmd(8'h20);
      check("R9 reconnect", connected, 1);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      t_reset();
      rst_n = 1'b1;
      repeat (HOLD) @(negedge clk);
      t_reset();
      t_probe_connect();
      t_disconnect();
      t_break();
      t_fe_restart();
      t_abort();
      t_unknown();
      t_repeat_disc();
      finished = 1'b1;
      $display("test done: total=%0d bad=%0d", n_checks, n_bad);
      $finish;
   end

   initial begin
      repeat (WATCHDOG) @(posedge clk);
      if (!finished) begin
         n_checks++;
         n_bad++;
         $display("FAIL watchdog actual=0x0 expected=0x1");
         $display("test done: total=%0d bad=%0d", n_checks, n_bad);
         $finish;
      end
   end

endmodule